// File: doc/BRIEF.md
# Full-Duplex SPI Packet Slave with Ready Handshake

This block is the device side of a mode-0 SPI link. Every exchange is one fixed 32-bit packet. The upper 8 bits are a packet ID and the lower 24 bits are payload. An active-low select frames exactly one packet. The block samples the host's serial clock and data with the system clock, so it needs no second clock domain. It tells the host when it may start clocking by pulling an active-low ready line.

On the chip side, logic pushes outgoing packets into a small FIFO. Each word the host clocks in comes back out on a packet output with a one-cycle valid strobe. The link is full duplex, so the host always receives a meaningful word while it sends one:

- If the FIFO holds a packet, the block sends the head of the FIFO.
- If the FIFO is empty and the block is enabled, it sends the current status word.
- If the FIFO is empty and the block is disabled, it sends all zeros.

A queued packet leaves the FIFO only after all 32 bits of its exchange complete. An aborted exchange therefore resends the same packet.

Top module: `spi_pkt_slave`

## Requirements
- R1: After the 32nd rising SCK edge of a selected exchange, `rx_pkt` holds the MOSI word with the first bit at bit 31, and `rx_valid` is high for exactly one clock.
- R2: MISO presents the outgoing word with bit 31 first. Bit 31 is present as soon as ready goes low, and each later bit appears after a falling SCK edge.
- R3: `spi_rdy_n` goes low on the 4th system clock edge after select is driven low. The same edge enables the MISO driver (`spi_miso_oe`).
- R4: While `spi_rdy_n` is high, the MISO driver is off and MISO is high impedance. Ready returns high on the 3rd clock edge after select is driven high.
- R5: Queued packets are sent in push order. A packet is removed from the queue only when its 32-bit exchange completes.
- R6: With the queue empty and `enable` high, the word sent is `status_word` as sampled when select is detected low.
- R7: With the queue empty and `enable` low, the word sent is 32'h0000_0000.
- R8: If select rises before 32 bits are clocked, no `rx_valid` is produced and the queue is not popped. The next exchange sends the same queued packet.
- R9: `tx_full` is high when the queue holds `TXQ_DEPTH` (default 4) entries. A push while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low select, one packet per assertion |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high impedance when not driven |
| spi_miso_oe | output | 1 | Enable of the MISO driver |
| spi_rdy_n | output | 1 | Active-low ready to host |
| enable | input | 1 | Selects status word over zero word when queue is empty |
| status_word | input | 32 | Fallback packet when enabled and queue is empty |
| tx_pkt | input | 32 | Packet to queue |
| tx_push | input | 1 | Push `tx_pkt` into the queue |
| tx_full | output | 1 | Queue full |
| rx_pkt | output | 32 | Last complete received packet |
| rx_valid | output | 1 | One-cycle strobe for `rx_pkt` |

## Verification
Ready timing has two fixed offsets, each counted at falling system-clock edges:

- **Select low:** the two-flop synchronizer and the load register place the ready fall on the 4th rising edge after select drops. The bench checks that ready is still high after three edges and low after the fourth.
- **Select high:** the release lands on the 3rd edge after select rises, and the bench checks both sides of that edge in the same way.

Serial timing leaves margin on every bit:

- The bench holds each SCK phase for six system clocks, which exceeds the three-clock synchronizer-plus-edge latency.
- MISO is read just before each rising SCK, after the preceding fall has shifted the register.
- `rx_valid` is captured at falling clock edges by a monitor. That lets the checks after each exchange count strobes rather than predict an exact cycle.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int ID_W   = 8;
  localparam int INFO_W = 24;
  localparam int PKT_W  = ID_W + INFO_W;
  typedef logic [PKT_W-1:0] pkt_t;
  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_XFER} phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= RST;
      st2_q <= RST;
    end else begin
      st1_q <= d;
      st2_q <= st1_q;
    end
  end

  assign q = st2_q;
endmodule

// File: rtl/pkt_txq.sv
module pkt_txq #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en, rd_en;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (wr_en) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (rd_en) rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign level = cnt_q;
endmodule

// File: rtl/pkt_shift_engine.sv
module pkt_shift_engine
  import spi_pkt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic mosi_bit,
  input  logic sel_fall,
  input  logic sel_rise,
  input  pkt_t load_word,
  input  logic load_from_q,
  output logic miso_bit,
  output logic miso_oe,
  output logic rdy_n,
  output pkt_t rx_word,
  output logic rx_strobe,
  output logic q_pop
);
  localparam int CW = $clog2(PKT_W + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  pkt_t          txs_q, txs_d, rxs_q, rxs_d, rxo_q, rxo_d;
  logic          rdy_q, rdy_d, held_q, held_d, stb_q, stb_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    rxo_d  = rxo_q;
    rdy_d  = rdy_q;
    held_d = held_q;
    stb_d  = 1'b0;
    q_pop  = 1'b0;
    if (sel_rise) begin
      ph_d  = PH_IDLE;
      rdy_d = 1'b1;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (sel_fall) begin
          txs_d  = load_word;
          held_d = load_from_q;
          cnt_d  = '0;
          ph_d   = PH_LOAD;
        end
        PH_LOAD: begin
          rdy_d = 1'b0;
          ph_d  = PH_XFER;
        end
        default: begin
          if (sck_rise && (cnt_q < CW'(PKT_W))) begin
            rxs_d = {rxs_q[PKT_W-2:0], mosi_bit};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CW'(PKT_W - 1)) begin
              rxo_d = {rxs_q[PKT_W-2:0], mosi_bit};
              stb_d = 1'b1;
              q_pop = held_q;
            end
          end
          if (sck_fall && (cnt_q != '0)) txs_d = {txs_q[PKT_W-2:0], 1'b0};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      rxo_q  <= '0;
      rdy_q  <= 1'b1;
      held_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      rxo_q  <= rxo_d;
      rdy_q  <= rdy_d;
      held_q <= held_d;
      stb_q  <= stb_d;
    end
  end

  assign miso_bit  = txs_q[PKT_W-1];
  assign miso_oe   = !rdy_q;
  assign rdy_n     = rdy_q;
  assign rx_word   = rxo_q;
  assign rx_strobe = stb_q;
endmodule

// File: rtl/spi_pkt_slave.sv
module spi_pkt_slave
  import spi_pkt_pkg::*;
#(
  parameter int TXQ_DEPTH = 4,
  localparam int QCW      = $clog2(TXQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  output logic             spi_rdy_n,
  input  logic             enable,
  input  logic [PKT_W-1:0] status_word,
  input  logic [PKT_W-1:0] tx_pkt,
  input  logic             tx_push,
  output logic             tx_full,
  output logic [PKT_W-1:0] rx_pkt,
  output logic             rx_valid
);
  logic [1:0]     rst_pipe;
  logic           rst_ni;
  logic [2:0]     pins_s;
  logic           cs_s, sck_s, mosi_s, cs_prev, sck_prev;
  logic           q_empty, q_pop, miso_b;
  logic [QCW-1:0] q_level;
  pkt_t           q_head, load_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  spi_pin_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s)
  );
  assign {cs_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
    end
  end

  pkt_txq #(.W(PKT_W), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_ni), .push(tx_push), .din(tx_pkt), .pop(q_pop),
    .head(q_head), .empty(q_empty), .full(tx_full), .level(q_level)
  );

  always_comb begin
    if (!q_empty)    load_word = q_head;
    else if (enable) load_word = status_word;
    else             load_word = '0;
  end

  pkt_shift_engine u_eng (
    .clk(clk), .rst_n(rst_ni),
    .sck_rise(sck_s && !sck_prev), .sck_fall(!sck_s && sck_prev),
    .mosi_bit(mosi_s),
    .sel_fall(!cs_s && cs_prev), .sel_rise(cs_s && !cs_prev),
    .load_word(load_word), .load_from_q(!q_empty),
    .miso_bit(miso_b), .miso_oe(spi_miso_oe), .rdy_n(spi_rdy_n),
    .rx_word(rx_pkt), .rx_strobe(rx_valid), .q_pop(q_pop)
  );

  assign spi_miso = spi_miso_oe ? miso_b : 1'bz;
endmodule

// File: rtl/spi_pkt_slave_chk.sv
module spi_pkt_slave_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_sync,
  input logic             rdy_n,
  input logic             miso_oe,
  input logic             rx_valid,
  input logic             tx_full,
  input logic             tx_push,
  input logic             q_pop,
  input logic [CNT_W-1:0] q_level
);
  AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R1
  AST_RDY_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> !cs_sync); // R3
  AST_RDY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sync && $past(cs_sync)) |-> rdy_n); // R4
  AST_OE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !rdy_n); // R4
  AST_POP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> rx_valid); // R5
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !q_pop) |=> tx_full); // R9
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= CNT_W'(DEPTH)); // R9
endmodule

bind spi_pkt_slave spi_pkt_slave_chk #(.DEPTH(TXQ_DEPTH), .CNT_W(QCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_s), .rdy_n(spi_rdy_n),
  .miso_oe(spi_miso_oe), .rx_valid(rx_valid), .tx_full(tx_full),
  .tx_push(tx_push), .q_pop(q_pop), .q_level(q_level)
);

// File: tb/sim_spi_pkt_slave.sv
module sim_spi_pkt_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, enable = 1'b1, tx_push = 1'b0;
  logic [31:0] status_word = 32'h5A00_0001, tx_pkt = '0;
  wire         miso;
  logic        miso_oe, rdy_n, tx_full, rx_valid;
  logic [31:0] rx_pkt;
  int          n_chk = 0, n_err = 0, rx_seen = 0;
  logic [31:0] rx_last = '0;

  localparam logic [63:0] VEC [4] = '{
    {32'hA5C3_0F11, 32'h8000_0001},
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'h7E12_3456, 32'h1234_5678},
    {32'hFFFF_FFFF, 32'hC0DE_BEEF}
  };

  always #10 clk = ~clk;

  spi_pkt_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .spi_rdy_n(rdy_n), .enable(enable),
    .status_word(status_word), .tx_pkt(tx_pkt), .tx_push(tx_push),
    .tx_full(tx_full), .rx_pkt(rx_pkt), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin
    rx_seen <= rx_seen + 1;
    rx_last <= rx_pkt;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); tx_pkt = w; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] mo, input int nbits, output logic [31:0] mi);
    int w;
    mi = '0;
    @(negedge clk); cs_n = 1'b0;
    w = 0;
    while (rdy_n && w < 50) begin @(negedge clk); w++; end
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[31-i];
      repeat (6) @(negedge clk);
      mi = {mi[30:0], miso};
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int          seen0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 reset rdy_n", {31'b0, rdy_n}, 32'd1);
    chk("R4 reset miso_oe", {31'b0, miso_oe}, 32'd0);
    chk("R1 reset rx_valid", {31'b0, rx_valid}, 32'd0);
    chk("R9 reset tx_full", {31'b0, tx_full}, 32'd0);

    // R1 R2 R5: table of host words and queued device words
    for (int v = 0; v < 4; v++) begin
      seen0 = rx_seen;
      push(VEC[v][31:0]);
      xfer(VEC[v][63:32], 32, got);
      chk("R1 rx word", rx_last, VEC[v][63:32]);
      chk("R1 one strobe", rx_seen - seen0, 32'd1);
      chk("R2 miso word", got, VEC[v][31:0]);
    end

    // R3 R4: ready timing, queue empty and enabled so status MSB is presented (R6)
    status_word = 32'h8123_4567;
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 rdy_n before edge 4", {31'b0, rdy_n}, 32'd1);
    chk("R4 oe off before ready", {31'b0, miso_oe}, 32'd0);
    @(negedge clk);
    chk("R3 rdy_n at edge 4", {31'b0, rdy_n}, 32'd0);
    chk("R3 oe on", {31'b0, miso_oe}, 32'd1);
    chk("R2 first bit", {31'b0, miso}, 32'd1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 rdy_n before release", {31'b0, rdy_n}, 32'd0);
    @(negedge clk);
    chk("R4 rdy_n released", {31'b0, rdy_n}, 32'd1);
    chk("R4 oe released", {31'b0, miso_oe}, 32'd0);
    repeat (4) @(negedge clk);

    // R8: abort keeps queued word
    seen0 = rx_seen;
    push(32'h0BAD_CAFE);
    xfer(32'h1111_2222, 10, got);
    chk("R8 no strobe on abort", rx_seen - seen0, 32'd0);
    xfer(32'h3333_4444, 32, got);
    chk("R8 resend after abort", got, 32'h0BAD_CAFE);
    chk("R1 after abort", rx_last, 32'h3333_4444);

    // R9 R5 R6: fill queue, extra push dropped, order kept, then status
    for (int k = 0; k < 4; k++) push(32'h1000_0000 + k);
    chk("R9 full at depth", {31'b0, tx_full}, 32'd1);
    push(32'hDEAD_0099);
    for (int k = 0; k < 4; k++) begin
      xfer(32'h0, 32, got);
      chk("R5 fifo order", got, 32'h1000_0000 + k);
    end
    chk("R9 not full after drain", {31'b0, tx_full}, 32'd0);
    status_word = 32'h42AB_CDEF;
    xfer(32'h0, 32, got);
    chk("R6 status when empty", got, 32'h42AB_CDEF);

    // R7: disabled and empty
    enable = 1'b0;
    xfer(32'h0, 32, got);
    chk("R7 zero when disabled", got, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule